// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is the host-facing mailbox of a keyboard controller. A host bus and an embedded controller CPU exchange bytes through it: the host deposits commands or data into an inbound byte register, the controller places replies in an outbound byte register, and a status byte reports which side has work pending. The host selects the status byte or the outbound data with one address line. The same line, during a host write, marks the inbound byte as a command or as data.

Two interrupt lines are driven, one for keyboard and one for mouse. A small state machine, `irq_mode`, has two states. In `MODE_DIRECT` each line copies its own bit of an 8-bit controller-owned port register. A single-cycle strobe from the controller takes the transition `DIRECT_TO_FLAGS`. The machine then sits in `MODE_FLAGS` under the self-loop `FLAGS_HOLD` until reset. In that state the keyboard line shows the outbound-full flag and the mouse line shows the inverse of the inbound-full flag, each only while its port bit is 1.

Each byte register has its own two-state machine (`BUF_EMPTY`, `BUF_FULL`) with these transitions:
- `FILL`: a write moves the register from empty to full.
- `REFILL`: a write while already full keeps it full.
- `DRAIN`: the consuming read moves it from full to empty.
- `IDLE`: with no write and no consuming read, an empty register stays empty.

A third port bit drives the address-20 gate output directly.

Top module: `kbc_host_mailbox`

## Requirements
- R1: While `rst_n` is low, and after it returns high, these are all 0: the status flags, the mode (`MODE_DIRECT`), the port register (default reset value 8'h00), `kbd_irq`, `mouse_irq` and `gate_a20`.
- R2: A cycle with `cpu_obuf_wr` high loads `cpu_wdata` into the outbound register and sets status bit 0 (outbound full) at that clock edge.
- R3: A host read with `host_a2`=0 returns the outbound byte on `host_rdata` in the same cycle and clears status bit 0 at the edge. If `cpu_obuf_wr` is high in the same cycle, bit 0 stays set.
- R4: A cycle with `host_wr` high loads `host_wdata` into the inbound register (visible on `cpu_ibuf_data`) and sets status bit 1 (inbound full). It also sets status bit 3 to the value of `host_a2`: 1 marks a command, 0 marks data.
- R5: A cycle with `cpu_ibuf_rd` high clears status bit 1. If `host_wr` is high in the same cycle, bit 1 stays set.
- R6: A host read with `host_a2`=1 returns the status byte and changes no flag. The status byte has bit 0 = outbound full, bit 1 = inbound full, bit 3 = command, and every other bit 0. `cpu_status` always carries the same byte.
- R7: In `MODE_DIRECT`, `kbd_irq` equals port bit 4 and `mouse_irq` equals port bit 5.
- R8: In `MODE_FLAGS`, `kbd_irq` = port bit 4 AND status bit 0, and `mouse_irq` = port bit 5 AND NOT status bit 1.
- R9: A one-cycle `cpu_en_flags` pulse moves the machine to `MODE_FLAGS` at that edge. It stays there, whatever later strobes arrive, until reset.
- R10: `gate_a20` equals port bit 1 in both modes.
- R11: A cycle with `cpu_port_wr` high loads the whole `cpu_wdata` byte into the port register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe to the inbound register |
| host_rd | input | 1 | Host read strobe |
| host_a2 | input | 1 | Host address select: 1 status/command, 0 data |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (status or outbound data) |
| cpu_obuf_wr | input | 1 | Controller write strobe to the outbound register |
| cpu_port_wr | input | 1 | Controller write strobe to the port register |
| cpu_wdata | input | 8 | Controller write byte |
| cpu_ibuf_rd | input | 1 | Controller read of the inbound register (consumes it) |
| cpu_en_flags | input | 1 | Single-cycle strobe entering flag-gated interrupt mode |
| cpu_ibuf_data | output | 8 | Inbound byte as seen by the controller |
| cpu_status | output | 8 | Status byte as seen by the controller |
| kbd_irq | output | 1 | Keyboard interrupt |
| mouse_irq | output | 1 | Mouse interrupt |
| gate_a20 | output | 1 | Address-20 gate output |

## Verification
- **Port byte sweep (direct mode):** all 256 port values are written. This separates the three routed bits from each other and from the unused bits.
- **Byte and address sweep:** all 256 bytes pass in each direction, with the address line alternating on host writes. This tells command marking apart from data marking and exposes any stuck or swapped data bit.
- **Flag-mode grid:** in flag mode the bench walks every combination of the two port bits with outbound-full and inbound-full. This distinguishes plain gating from direct following and checks the mouse line's inversion.
- **Collisions and stickiness:** same-cycle fill and drain are tried on both registers. Repeated strobes and a reset pin down the sticky mode.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
    // Port-register bit routing
    localparam int P_A20_BIT   = 1;
    localparam int P_KBD_BIT   = 4;
    localparam int P_MOUSE_BIT = 5;

    // Status byte layout
    localparam int ST_OBF_BIT = 0;
    localparam int ST_IBF_BIT = 1;
    localparam int ST_CMD_BIT = 3;

    typedef enum logic {
        MODE_DIRECT = 1'b0,
        MODE_FLAGS  = 1'b1
    } irq_mode_e;

    typedef enum logic {
        BUF_EMPTY = 1'b0,
        BUF_FULL  = 1'b1
    } buf_state_e;
endpackage

// File: rtl/kbc_mode_fsm.sv
module kbc_mode_fsm
    import kbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_flags,
    output logic flags_mode
);
    irq_mode_e mode_q, mode_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_DIRECT;
        else        mode_q <= mode_d;
    end

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_DIRECT: if (en_flags) mode_d = MODE_FLAGS;  // DIRECT_TO_FLAGS
            MODE_FLAGS:  mode_d = MODE_FLAGS;                // FLAGS_HOLD
            default:     mode_d = MODE_DIRECT;
        endcase
    end

    assign flags_mode = (mode_q == MODE_FLAGS);

    p_enter_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        en_flags |=> flags_mode);
    p_flags_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flags_mode |=> flags_mode);
endmodule

// File: rtl/kbc_port_reg.sv
module kbc_port_reg #(
    parameter int              DW      = 8,
    parameter logic [DW-1:0]   RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] port_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  port_q <= RST_VAL;
        else if (wr) port_q <= wdata;
    end

    p_port_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> port_q == $past(wdata));
endmodule

// File: rtl/kbc_mailbox_regs.sv
module kbc_mailbox_regs
    import kbc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic          host_a2,
    input  logic [DW-1:0] host_wdata,
    input  logic          cpu_obuf_wr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          cpu_ibuf_rd,
    output logic          obf,
    output logic          ibf,
    output logic          cmd,
    output logic [DW-1:0] ibuf_q,
    output logic [DW-1:0] obuf_q
);
    buf_state_e ob_q, ob_d, ib_q, ib_d;
    logic       host_data_rd;

    assign host_data_rd = host_rd && !host_a2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ob_q <= BUF_EMPTY;
            ib_q <= BUF_EMPTY;
        end else begin
            ob_q <= ob_d;
            ib_q <= ib_d;
        end
    end

    // Outbound buffer: controller fills, host data read drains; fill wins
    always_comb begin
        ob_d = ob_q;
        unique case (ob_q)
            BUF_EMPTY: if (cpu_obuf_wr) ob_d = BUF_FULL;        // FILL
            BUF_FULL:  if (cpu_obuf_wr) ob_d = BUF_FULL;        // REFILL
                       else if (host_data_rd) ob_d = BUF_EMPTY; // DRAIN
            default:   ob_d = BUF_EMPTY;
        endcase
    end

    // Inbound buffer: host fills, controller read drains; fill wins
    always_comb begin
        ib_d = ib_q;
        unique case (ib_q)
            BUF_EMPTY: if (host_wr) ib_d = BUF_FULL;            // FILL
            BUF_FULL:  if (host_wr) ib_d = BUF_FULL;            // REFILL
                       else if (cpu_ibuf_rd) ib_d = BUF_EMPTY;  // DRAIN
            default:   ib_d = BUF_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            obuf_q <= '0;
            ibuf_q <= '0;
            cmd    <= 1'b0;
        end else begin
            if (cpu_obuf_wr) obuf_q <= cpu_wdata;
            if (host_wr) begin
                ibuf_q <= host_wdata;
                cmd    <= host_a2;
            end
        end
    end

    assign obf = (ob_q == BUF_FULL);
    assign ibf = (ib_q == BUF_FULL);

    p_obf_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_obuf_wr |=> obf && obuf_q == $past(cpu_wdata));
    p_obf_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        host_data_rd && !cpu_obuf_wr |=> !obf);
    p_ibf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> ibf && cmd == $past(host_a2));
    p_ibf_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ibuf_rd && !host_wr |=> !ibf);
    p_status_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && host_a2 && !host_wr && !cpu_obuf_wr && !cpu_ibuf_rd
        |=> $stable(obf) && $stable(ibf) && $stable(cmd));
endmodule

// File: rtl/kbc_host_mailbox.sv
module kbc_host_mailbox
    import kbc_pkg::*;
#(
    parameter int            DW       = 8,
    parameter logic [DW-1:0] PORT_RST = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic          host_a2,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          cpu_obuf_wr,
    input  logic          cpu_port_wr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          cpu_ibuf_rd,
    input  logic          cpu_en_flags,
    output logic [DW-1:0] cpu_ibuf_data,
    output logic [DW-1:0] cpu_status,
    output logic          kbd_irq,
    output logic          mouse_irq,
    output logic          gate_a20
);
    logic          obf, ibf, cmd, flags_mode;
    logic [DW-1:0] obuf_q, port_q, status;

    kbc_mailbox_regs #(.DW(DW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr     (host_wr),
        .host_rd     (host_rd),
        .host_a2     (host_a2),
        .host_wdata  (host_wdata),
        .cpu_obuf_wr (cpu_obuf_wr),
        .cpu_wdata   (cpu_wdata),
        .cpu_ibuf_rd (cpu_ibuf_rd),
        .obf         (obf),
        .ibf         (ibf),
        .cmd         (cmd),
        .ibuf_q      (cpu_ibuf_data),
        .obuf_q      (obuf_q)
    );

    kbc_port_reg #(.DW(DW), .RST_VAL(PORT_RST)) u_port (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cpu_port_wr),
        .wdata  (cpu_wdata),
        .port_q (port_q)
    );

    kbc_mode_fsm u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_flags   (cpu_en_flags),
        .flags_mode (flags_mode)
    );

    always_comb begin
        status             = '0;
        status[ST_OBF_BIT] = obf;
        status[ST_IBF_BIT] = ibf;
        status[ST_CMD_BIT] = cmd;
    end

    assign cpu_status = status;
    assign host_rdata = host_a2 ? status : obuf_q;

    // Interrupt steering: direct port bits, or flags gated by port bits
    always_comb begin
        if (flags_mode) begin
            kbd_irq   = port_q[P_KBD_BIT]   & obf;
            mouse_irq = port_q[P_MOUSE_BIT] & ~ibf;
        end else begin
            kbd_irq   = port_q[P_KBD_BIT];
            mouse_irq = port_q[P_MOUSE_BIT];
        end
    end

    assign gate_a20 = port_q[P_A20_BIT];

    p_direct_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_mode |-> kbd_irq == port_q[P_KBD_BIT] && mouse_irq == port_q[P_MOUSE_BIT]);
    p_flags_kbd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flags_mode && !obf |-> !kbd_irq);
    p_flags_mouse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flags_mode && ibf |-> !mouse_irq);
    p_a20_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_port_wr |=> gate_a20 == $past(cpu_wdata[P_A20_BIT]));
endmodule

// File: tb/test_kbc_host_mailbox.sv
module test_kbc_host_mailbox;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 0, host_rd = 0, host_a2 = 0;
    logic [7:0] host_wdata = 0, cpu_wdata = 0;
    logic       cpu_obuf_wr = 0, cpu_port_wr = 0, cpu_ibuf_rd = 0, cpu_en_flags = 0;
    logic [7:0] host_rdata, cpu_ibuf_data, cpu_status;
    logic       kbd_irq, mouse_irq, gate_a20;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;  // 125 MHz

    kbc_host_mailbox i_kbc_host_mailbox (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_a2(host_a2),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cpu_obuf_wr(cpu_obuf_wr), .cpu_port_wr(cpu_port_wr), .cpu_wdata(cpu_wdata),
        .cpu_ibuf_rd(cpu_ibuf_rd), .cpu_en_flags(cpu_en_flags),
        .cpu_ibuf_data(cpu_ibuf_data), .cpu_status(cpu_status),
        .kbd_irq(kbd_irq), .mouse_irq(mouse_irq), .gate_a20(gate_a20)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply current strobes across one rising edge, then release them
    task automatic tick();
        @(negedge clk);
        host_wr = 0; host_rd = 0; cpu_obuf_wr = 0; cpu_port_wr = 0;
        cpu_ibuf_rd = 0; cpu_en_flags = 0;
    endtask

    function automatic logic [7:0] stat(input bit o, input bit i, input bit c);
        return {4'b0, c, 1'b0, i, o};
    endfunction

    task automatic port_wr(input logic [7:0] v);
        cpu_port_wr = 1; cpu_wdata = v; tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic exp_obf, exp_ibf;
        repeat (3) @(negedge clk);
        // R1 during and after reset
        chk("R1 status in reset", cpu_status, 8'h00);
        chk("R1 irqs in reset", {5'b0, kbd_irq, mouse_irq, gate_a20}, 8'h00);
        rst_n = 1;
        @(negedge clk);
        chk("R1 status after reset", cpu_status, 8'h00);
        chk("R1 irqs after reset", {5'b0, kbd_irq, mouse_irq, gate_a20}, 8'h00);

        // R11, R7, R10: sweep all port values in direct mode
        for (int v = 0; v < 256; v++) begin
            port_wr(8'(v));
            chk("R7 kbd direct", {7'b0, kbd_irq}, {7'b0, v[4]});
            chk("R7 mouse direct", {7'b0, mouse_irq}, {7'b0, v[5]});
            chk("R10 R11 gate", {7'b0, gate_a20}, {7'b0, v[1]});
        end

        // R4, R6, R5: inbound sweep with alternating address line
        for (int v = 0; v < 256; v++) begin
            host_wr = 1; host_a2 = v[0]; host_wdata = 8'(v); tick();
            chk("R4 inbound byte", cpu_ibuf_data, 8'(v));
            host_rd = 1; host_a2 = 1; #1;
            chk("R6 R4 status read", host_rdata, stat(0, 1, v[0]));
            tick();
            chk("R6 flags unchanged", cpu_status, stat(0, 1, v[0]));
            cpu_ibuf_rd = 1; tick();
            chk("R5 ibf cleared", cpu_status, stat(0, 0, v[0]));
        end

        // R2, R3: outbound sweep
        for (int v = 0; v < 256; v++) begin
            cpu_obuf_wr = 1; cpu_wdata = 8'(v ^ 8'h5A); tick();
            chk("R2 obf set", {7'b0, cpu_status[0]}, 8'h01);
            host_rd = 1; host_a2 = 0; #1;
            chk("R3 data read", host_rdata, 8'(v ^ 8'h5A));
            tick();
            chk("R3 obf cleared", {7'b0, cpu_status[0]}, 8'h00);
        end

        // R3 collision: write wins over host drain
        cpu_obuf_wr = 1; cpu_wdata = 8'h11; tick();
        cpu_obuf_wr = 1; cpu_wdata = 8'h22; host_rd = 1; host_a2 = 0; tick();
        chk("R3 collision obf", {7'b0, cpu_status[0]}, 8'h01);
        host_rd = 1; host_a2 = 0; #1;
        chk("R3 collision data", host_rdata, 8'h22);
        tick();
        // R5 collision: host write wins over controller read
        host_wr = 1; host_a2 = 0; host_wdata = 8'h33; tick();
        host_wr = 1; host_a2 = 1; host_wdata = 8'h44; cpu_ibuf_rd = 1; tick();
        chk("R5 collision", cpu_status, stat(0, 1, 1));
        chk("R5 collision data", cpu_ibuf_data, 8'h44);
        cpu_ibuf_rd = 1; tick();

        // R9: enter flag mode, R8 grid
        port_wr(8'h00);
        cpu_en_flags = 1; tick();
        for (int p = 0; p < 4; p++) begin
            for (int s = 0; s < 4; s++) begin
                exp_obf = s[0]; exp_ibf = s[1];
                if (exp_obf) begin cpu_obuf_wr = 1; cpu_wdata = 8'h77; end
                else begin host_rd = 1; host_a2 = 0; end
                if (exp_ibf) begin host_wr = 1; host_a2 = 0; host_wdata = 8'h66; end
                else cpu_ibuf_rd = 1;
                tick();
                port_wr({2'b0, p[1], p[0], 4'b0010});
                chk("R8 kbd flags", {7'b0, kbd_irq}, {7'b0, p[0] & exp_obf});
                chk("R8 mouse flags", {7'b0, mouse_irq}, {7'b0, p[1] & ~exp_ibf});
                chk("R10 gate flags", {7'b0, gate_a20}, 8'h01);
            end
        end
        // R9 sticky under repeated strobe
        cpu_en_flags = 1; tick();
        host_rd = 1; host_a2 = 0; tick();
        cpu_ibuf_rd = 1; tick();
        port_wr(8'h30);
        chk("R9 still flags kbd", {7'b0, kbd_irq}, 8'h00);
        chk("R9 still flags mouse", {7'b0, mouse_irq}, 8'h01);
        // R9 reset returns to direct mode
        rst_n = 0; @(negedge clk);
        chk("R1 port reset", {5'b0, kbd_irq, mouse_irq, gate_a20}, 8'h00);
        rst_n = 1; @(negedge clk);
        port_wr(8'h10);
        chk("R9 direct after reset", {7'b0, kbd_irq}, 8'h01);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule